// File: doc/BRIEF.md
# Transmit Re-timing Elastic Buffer

This block carries a serial NRZ transmit bit stream from the clock recovered out of that stream into a local read clock, and absorbs slow, bounded phase wander between the two. It is a one-bit-wide elastic store. The write pointer starts half the depth ahead of the read pointer, so the fill level begins at the centre and can move in either direction. When wander drives the store to full or to empty, a sticky error flag is set. The flag also serves as an interrupt source. A re-centre request restores both pointers and clears the flag. It is needed once the transmit clocks are stable after power-up.

A two-bit timing-mode input picks the data path. Code 2'b10 re-times through the store on the reference clock. Code 2'b11 does the same with the receive recovered clock as the read clock. Code 2'b01 bypasses the store and needs no re-centre. The reserved code 2'b00 behaves as 2'b01. The reset input, the re-centre request and the FIFO-enable part of the mode are each synchronised into both clock domains. Pointers cross between domains in Gray code through two-flop synchronisers.

Top module: `txre_elastic_fifo`

## Requirements
- R1: While `rst` is held and after it is released, `fifo_err` is 0 and `nrz_out` is 0 until data flows.
- R2: In mode 2'b10, `nrz_out` repeats `nrz_in` with a fixed delay of DEPTH/2 plus a few read cycles, in the range DEPTH/2-3 to DEPTH/2+6 cycles when the clocks run at equal rates.
- R3: After a re-centre, the write pointer is DEPTH/2 ahead of the read pointer. Net phase drift of up to ±4 bits raises no error.
- R4: A sustained surplus of write edges drives the store to full as seen from the write side, and sets `fifo_err`.
- R5: A sustained deficit of write edges drives the store to empty as seen from the read side, and sets `fifo_err`.
- R6: Once set, `fifo_err` stays 1 in the FIFO modes until a re-centre, even after the clocks match again.
- R7: `recentre` (or `rst`), held for at least 4 cycles of the slower clock, clears `fifo_err` and re-centres the pointers. It wins over an overrun or underrun detected in the same cycle.
- R8: In modes 2'b01 and 2'b00, `nrz_out` is `nrz_in` registered on one `tx_clk` edge, and `fifo_err` stays 0 under any drift.
- R9: In mode 2'b11, the read side runs on `rx_clk`, keeps the R2 delay and raises no error while `ref_clk` is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | System reference clock, read clock in mode 2'b10 |
| rx_clk | input | 1 | Receive recovered clock, read clock in mode 2'b11 |
| tx_clk | input | 1 | Clock recovered from the transmit NRZ data, write clock |
| rst | input | 1 | Active-high reset, synchronised into both domains |
| recentre | input | 1 | Re-centre request, level held for at least 4 slow-clock cycles |
| mode | input | 2 | Timing mode: 10 re-time, 11 loop-timing, 01 and 00 bypass |
| nrz_in | input | 1 | NRZ transmit data, sampled on `tx_clk` |
| nrz_out | output | 1 | Re-timed or bypassed NRZ data |
| fifo_err | output | 1 | Sticky overrun or underrun flag, read-clock domain |

## Verification
The re-centre request and the slip detection can act in the same read cycle. The bench provokes this by leaving the write clock fast, so that the overrun condition persists, while it asserts `recentre`. The flag must read 0 while the request is still held, and stay 0 after release once the clocks match again. A pass therefore shows that the clear takes priority over a fresh detection, and that the pointers came back to the centre.

// File: rtl/txre_pkg.sv
`timescale 1ns/1ps
package txre_pkg;

  // Timing-mode codes; bit 1 set means the elastic store is in the path
  typedef enum logic [1:0] {
    TM_RSVD   = 2'b00,
    TM_PLESIO = 2'b01,
    TM_SYNC   = 2'b10,
    TM_LOOP   = 2'b11
  } tmode_e;

endpackage

// File: rtl/txre_sync2.sv
`timescale 1ns/1ps
// Two-flop level synchroniser
module txre_sync2 (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    meta <= d;
    q    <= meta;
  end
endmodule

// File: rtl/txre_gray_xfer.sv
`timescale 1ns/1ps
// Binary pointer -> registered Gray -> two destination flops -> binary
module txre_gray_xfer #(
  parameter int W = 6
) (
  input  logic         src_clk,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] gray_src;
  logic [W-1:0] gray_meta;
  logic [W-1:0] gray_dst;

  always_ff @(posedge src_clk)
    gray_src <= src_bin ^ (src_bin >> 1);

  always_ff @(posedge dst_clk) begin
    gray_meta <= gray_src;
    gray_dst  <= gray_meta;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_dec
      assign dst_bin[i] = ^gray_dst[W-1:i];
    end
  endgenerate
endmodule

// File: rtl/txre_bit_ram.sv
`timescale 1ns/1ps
// One-bit dual-clock store, registered read port (block RAM friendly)
module txre_bit_ram #(
  parameter int AW = 5
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          rd_clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  localparam int WORDS = 1 << AW;

  logic store [0:WORDS-1];

  always_ff @(posedge wr_clk)
    if (we) store[waddr] <= wdata;

  always_ff @(posedge rd_clk)
    if (re) rdata <= store[raddr];
endmodule

// File: rtl/txre_wr_side.sv
`timescale 1ns/1ps
// Write domain: pointer, overrun detection, bypass register
module txre_wr_side #(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       clr,
  input  logic                       run,
  input  logic                       din,
  input  logic [$clog2(DEPTH):0]     rd_seen,
  output logic [$clog2(DEPTH):0]     wr_bin,
  output logic                       we,
  output logic                       ovf,
  output logic                       byp_q
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CENTRE = PW'(DEPTH / 2);
  localparam logic [PW-1:0] FULL   = PW'(DEPTH);

  logic [PW-1:0] fill;

  assign fill = wr_bin - rd_seen;
  assign we   = run && !clr;

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_bin <= CENTRE;
      ovf    <= 1'b0;
      byp_q  <= 1'b0;
    end else begin
      byp_q <= din;
      if (run) begin
        wr_bin <= wr_bin + 1'b1;
        if (fill == FULL) ovf <= 1'b1;
      end else begin
        ovf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txre_rd_side.sv
`timescale 1ns/1ps
// Read domain: pointer, underrun detection, sticky error, output bit
module txre_rd_side #(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       clr,
  input  logic                       run,
  input  logic [$clog2(DEPTH):0]     wr_seen,
  input  logic                       ovf_seen,
  input  logic                       mem_q,
  output logic [$clog2(DEPTH):0]     rd_bin,
  output logic                       re,
  output logic                       bit_q,
  output logic                       err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] fill;
  logic          slip;

  assign fill = wr_seen - rd_bin;
  assign slip = (fill == '0) || ovf_seen;
  assign re   = run && !clr;

  always_ff @(posedge clk) begin
    if (clr) begin
      rd_bin <= '0;
      bit_q  <= 1'b0;
      err    <= 1'b0;
    end else if (run) begin
      rd_bin <= rd_bin + 1'b1;
      bit_q  <= mem_q;
      if (slip) err <= 1'b1;
    end else begin
      bit_q <= 1'b0;
      err   <= 1'b0;
    end
  end
endmodule

// File: rtl/txre_elastic_fifo.sv
`timescale 1ns/1ps
// Transmit re-timing elastic buffer (DEPTH must be a power of two)
module txre_elastic_fifo #(
  parameter int DEPTH = 32
) (
  input  logic       ref_clk,
  input  logic       rx_clk,
  input  logic       tx_clk,
  input  logic       rst,
  input  logic       recentre,
  input  logic [1:0] mode,
  input  logic       nrz_in,
  output logic       nrz_out,
  output logic       fifo_err
);
  import txre_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  tmode_e        mode_e;
  logic          loop_sel;
  logic          fifo_sel;
  logic          rd_clk;
  logic          clr_req;
  logic          wr_clr;
  logic          rd_clr;
  logic          wr_run;
  logic          rd_run;
  logic          ovf_wr;
  logic          ovf_rd;
  logic          we;
  logic          re;
  logic          mem_q;
  logic          rd_bit;
  logic          byp_bit;
  logic [PW-1:0] wr_bin;
  logic [PW-1:0] rd_bin;
  logic [PW-1:0] wr_seen;
  logic [PW-1:0] rd_seen;

  assign mode_e   = tmode_e'(mode);
  assign loop_sel = (mode_e == TM_LOOP);
  assign fifo_sel = (mode_e == TM_SYNC) || (mode_e == TM_LOOP);
  assign rd_clk   = loop_sel ? rx_clk : ref_clk;
  assign clr_req  = rst || recentre;

  txre_sync2 u_wr_clr (.clk(tx_clk), .d(clr_req),  .q(wr_clr));
  txre_sync2 u_rd_clr (.clk(rd_clk), .d(clr_req),  .q(rd_clr));
  txre_sync2 u_wr_run (.clk(tx_clk), .d(fifo_sel), .q(wr_run));
  txre_sync2 u_rd_run (.clk(rd_clk), .d(fifo_sel), .q(rd_run));
  txre_sync2 u_ovf    (.clk(rd_clk), .d(ovf_wr),   .q(ovf_rd));

  txre_gray_xfer #(.W(PW)) u_w2r (
    .src_clk(tx_clk), .src_bin(wr_bin), .dst_clk(rd_clk), .dst_bin(wr_seen)
  );
  txre_gray_xfer #(.W(PW)) u_r2w (
    .src_clk(rd_clk), .src_bin(rd_bin), .dst_clk(tx_clk), .dst_bin(rd_seen)
  );

  txre_wr_side #(.DEPTH(DEPTH)) u_wr (
    .clk(tx_clk), .clr(wr_clr), .run(wr_run), .din(nrz_in),
    .rd_seen(rd_seen), .wr_bin(wr_bin), .we(we), .ovf(ovf_wr), .byp_q(byp_bit)
  );

  txre_bit_ram #(.AW(AW)) u_ram (
    .wr_clk(tx_clk), .we(we), .waddr(wr_bin[AW-1:0]), .wdata(nrz_in),
    .rd_clk(rd_clk), .re(re), .raddr(rd_bin[AW-1:0]), .rdata(mem_q)
  );

  txre_rd_side #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .clr(rd_clr), .run(rd_run), .wr_seen(wr_seen),
    .ovf_seen(ovf_rd), .mem_q(mem_q), .rd_bin(rd_bin), .re(re),
    .bit_q(rd_bit), .err(fifo_err)
  );

  assign nrz_out = fifo_sel ? rd_bit : byp_bit;
endmodule

// File: rtl/txre_elastic_chk.sv
`timescale 1ns/1ps
module txre_elastic_chk #(
  parameter int PW   = 6,
  parameter int HALF = 16
) (
  input logic          rd_clk,
  input logic          tx_clk,
  input logic          rst,
  input logic          rd_clr,
  input logic          wr_clr,
  input logic          rd_run,
  input logic          wr_run,
  input logic [PW-1:0] rd_bin,
  input logic [PW-1:0] wr_bin,
  input logic          fifo_err
);
  AST_RD_CENTRE: assert property (@(posedge rd_clk) disable iff (rst)
    rd_clr |=> (rd_bin == '0)); // R3
  AST_WR_CENTRE: assert property (@(posedge tx_clk) disable iff (rst)
    wr_clr |=> (wr_bin == PW'(HALF))); // R3
  AST_RD_STEP: assert property (@(posedge rd_clk) disable iff (rst)
    (!rd_clr && rd_run) |=> (rd_bin == $past(rd_bin) + 1'b1)); // R2
  AST_WR_STEP: assert property (@(posedge tx_clk) disable iff (rst)
    (!wr_clr && wr_run) |=> (wr_bin == $past(wr_bin) + 1'b1)); // R2
  AST_ERR_STICKY: assert property (@(posedge rd_clk) disable iff (rst)
    (fifo_err && !rd_clr && rd_run) |=> fifo_err); // R6
  AST_CLR_ERR: assert property (@(posedge rd_clk) disable iff (rst)
    rd_clr |=> !fifo_err); // R7
  AST_BYPASS_QUIET: assert property (@(posedge rd_clk) disable iff (rst)
    !rd_run |=> !fifo_err); // R8
endmodule

bind txre_elastic_fifo txre_elastic_chk #(.PW(PW), .HALF(DEPTH / 2)) u_chk (
  .rd_clk(rd_clk), .tx_clk(tx_clk), .rst(rst), .rd_clr(rd_clr),
  .wr_clr(wr_clr), .rd_run(rd_run), .wr_run(wr_run), .rd_bin(rd_bin),
  .wr_bin(wr_bin), .fifo_err(fifo_err)
);

// File: tb/tb_txre_elastic_fifo.sv
`timescale 1ns/100ps
module tb_txre_elastic_fifo;
  localparam int DEPTH = 32;
  localparam int HALF  = DEPTH / 2;
  localparam int M     = 8192;

  logic       ref_clk = 1'b0;
  logic       rx_clk  = 1'b0;
  logic       tx_clk  = 1'b0;
  logic       rst     = 1'b1;
  logic       recentre = 1'b0;
  logic [1:0] mode    = 2'b10;
  logic       nrz_in  = 1'b0;
  logic       nrz_out;
  logic       fifo_err;
  logic       mon_clk;

  real tx_half = 5.0;
  bit  ref_en  = 1'b1;
  int  checks  = 0;
  int  errors  = 0;
  bit  done    = 1'b0;

  bit in_hist  [M];
  bit out_hist [M];
  int out_tag  [M];
  int in_cnt  = 0;
  int out_cnt = 0;

  // 100 MHz reference; receive clock and transmit clock at other phases
  initial forever begin #5; if (ref_en) ref_clk = ~ref_clk; end
  initial begin #2; forever #5 rx_clk = ~rx_clk; end
  initial begin #3.3; forever #(tx_half) tx_clk = ~tx_clk; end

  txre_elastic_fifo #(.DEPTH(DEPTH)) dut (
    .ref_clk(ref_clk), .rx_clk(rx_clk), .tx_clk(tx_clk), .rst(rst),
    .recentre(recentre), .mode(mode), .nrz_in(nrz_in),
    .nrz_out(nrz_out), .fifo_err(fifo_err)
  );

  assign mon_clk = (mode == 2'b11) ? rx_clk : ref_clk;

  always @(negedge tx_clk) nrz_in = 1'($urandom() & 32'd1);
  always @(posedge tx_clk) begin in_hist[in_cnt % M] = nrz_in; in_cnt++; end
  always @(negedge mon_clk) begin
    out_hist[out_cnt % M] = nrz_out;
    out_tag[out_cnt % M]  = in_cnt;
    out_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit lat_ok(input int k);
    return (k >= HALF - 3) && (k <= HALF + 6);
  endfunction

  // Find the constant input-to-output delay over a recent window
  task automatic find_lat(output int lat);
    lat = -1;
    for (int k = 0; k <= 40 && lat < 0; k++) begin
      bit ok = 1'b1;
      for (int j = 3; j < 153; j++) begin
        int o = out_cnt - j;
        if (out_hist[o % M] != in_hist[(out_tag[o % M] - k) % M]) ok = 1'b0;
      end
      if (ok) lat = k;
    end
  endtask

  task automatic recentre_pulse();
    recentre = 1'b1; #100; recentre = 1'b0; #100;
  endtask

  task automatic drift(input real half, input int dur);
    tx_half = half; #(dur); tx_half = 5.0;
  endtask

  task automatic bypass_run(input real half, input string req);
    int mism = 0;
    tx_half = half;
    repeat (200) @(negedge tx_clk)
      if (nrz_out !== in_hist[(in_cnt - 1) % M]) mism++;
    chk(mism == 0, {req, " bypass data"}, mism, 0);
    chk(fifo_err == 1'b0, {req, " bypass err"}, fifo_err, 0);
    tx_half = 5.0;
    @(negedge ref_clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'd20061));
    // R1 reset state
    #200;
    chk(fifo_err == 1'b0, "R1 err in reset", fifo_err, 0);
    chk(nrz_out == 1'b0, "R1 out in reset", nrz_out, 0);
    rst = 1'b0;
    #30;
    chk(fifo_err == 1'b0, "R1 err after reset", fifo_err, 0);
    #3000;
    find_lat(lat);
    chk(lat_ok(lat), "R2 sync delay", lat, HALF + 2);
    chk(fifo_err == 1'b0, "R3 steady", fifo_err, 0);

    // R3 random bounded wander episodes, each net zero
    repeat (4) begin
      int d = $urandom_range(4, 1);
      if ($urandom_range(1, 0) == 1) begin
        drift(4.0, 40 * d); #500; drift(6.0, 60 * d);
      end else begin
        drift(6.0, 60 * d); #500; drift(4.0, 40 * d);
      end
      #500;
      chk(fifo_err == 1'b0, "R3 wander", fifo_err, 0);
    end

    // R4 overrun, R6 sticky
    tx_half = 4.0; #1200;
    chk(fifo_err == 1'b1, "R4 overrun", fifo_err, 1);
    tx_half = 5.0; #500;
    chk(fifo_err == 1'b1, "R6 sticky", fifo_err, 1);

    // R7 re-centre while overrun persists
    tx_half = 4.0;
    recentre = 1'b1; #50;
    chk(fifo_err == 1'b0, "R7 clear during overrun", fifo_err, 0);
    #50; tx_half = 5.0; recentre = 1'b0; #100;
    chk(fifo_err == 1'b0, "R7 after release", fifo_err, 0);
    #3000;
    find_lat(lat);
    chk(lat_ok(lat), "R2 delay after recentre", lat, HALF + 2);

    // R5 underrun
    tx_half = 6.0; #2000;
    chk(fifo_err == 1'b1, "R5 underrun", fifo_err, 1);
    tx_half = 5.0;
    recentre_pulse();
    chk(fifo_err == 1'b0, "R7 clear after underrun", fifo_err, 0);

    // R8 bypass modes
    mode = 2'b01; #200;
    bypass_run(4.0, "R8 mode01");
    mode = 2'b00; #200;
    bypass_run(6.0, "R8 mode00");

    // R9 loop-timing with reference clock stopped
    mode = 2'b11;
    @(negedge ref_clk);
    recentre_pulse();
    ref_en = 1'b0;
    #3000;
    find_lat(lat);
    chk(lat_ok(lat), "R9 loop delay", lat, HALF + 2);
    chk(fifo_err == 1'b0, "R9 loop err", fifo_err, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule